// File: doc/BRIEF.md
# Frame-Synchronized Command Sequencer

The sequencer accepts register-write commands from a host and holds them until a chosen video frame begins, then presents them one at a time on a downstream command port. A command is built from two host writes to the same kind of location: the first supplies the target register address and the second supplies 32 bits of data. The location used for the first write selects the target frame. Locations 0 to 15 name an absolute frame number modulo 16. Location 16 means "as soon as possible". Locations 17 to 30 mean 1 to 14 frames ahead of the current one.

Location 31 is the control word. It can empty every queue, start or stop the sequencer, and manage a frame interrupt. A 4-bit frame counter advances on each frame-sync pulse while the sequencer runs. Sixteen per-frame queues and one immediate queue hold the pending commands. The interrupt reports that the current frame's commands have all been issued.

Top module: `frame_cmd_seq`

## Requirements
- R1: A write to any location other than 31, made while an address is expected, latches wrData[ADDR_W-1:0] as the command address. The next such write supplies the 32-bit data and enqueues the pair. A command leaves with that address on cmdAddr and that data on cmdData.
- R2: A write to location 31 returns the two-write toggle to the address phase, so the following non-control write is taken as an address.
- R3: Locations 0..15 target frame number loc[3:0]. If that number equals (current frame − 1) mod 16, the command goes to the current frame instead.
- R4: A command written to location 16 is issued while running, with no frame boundary needed. Pending immediate commands are issued before those of the current frame.
- R5: Locations 17..30 target (current frame + loc[3:0]) mod 16, which is 1 to 14 frames ahead and wraps past 15.
- R6: The frame counter starts at 0 and increments by one, mod 16, on a frameSync pulse only while running. Commands for the current frame leave in write order, one per cycle in which cmdValid and cmdReady are both high.
- R7: A control write with bit 14 set empties all queues and stops the sequencer. For the next 32 cycles no command is issued and enqueue writes are dropped.
- R8: Control bits [13:12] equal to 3 start the sequencer, 2 stops it, and 0 or 1 leave it unchanged. While stopped, cmdValid stays low.
- R9: Control bits [1:0] form an interrupt command: 0 no effect, 1 clear status, 2 clear enable, 3 set enable. irq is high exactly when both status and enable are set.
- R10: After a frame advance, status is set once the new current frame's queue is empty, one cycle after emptiness is seen.
- R11: Each queue holds DEPTH commands. A command written to a full queue is discarded.
- R12: After reset the sequencer is stopped, the frame is 0, all queues are empty, irq is low and the next write is an address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrLoc | input | 5 | Host write location (0..31) |
| wrData | input | 32 | Host write data |
| frameSync | input | 1 | One-cycle frame-start pulse |
| cmdReady | input | 1 | Downstream accepts a command |
| cmdValid | output | 1 | A command is presented |
| cmdAddr | output | ADDR_W | Command register address |
| cmdData | output | 32 | Command data |
| irq | output | 1 | Frame-commands-done interrupt |

## Verification
A wrong frame counter or a wrong target index does not corrupt data. It shows at the ports as a correct command emerging in the wrong frame. If the error is off by a whole wrap, the command appears up to 16 frames late, so the checks tie each delivered command to the frame count in which it appeared, not only to its order. A stuck two-write toggle shows at once as an address and data swap on the next command. A queue fill count that drifts shows either as a missing command or as cmdValid staying high with stale data. The cycle-accurate model catches this on the first cycle of divergence.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DATA_W   = 32;
  localparam int LOC_W    = 5;
  localparam int NUM_FRM  = 16;
  localparam int NUM_Q    = NUM_FRM + 1;
  localparam int ASAP_Q   = NUM_FRM;
  localparam int QIDX_W   = $clog2(NUM_Q);
  localparam logic [LOC_W-1:0] CTRL_LOC = 5'h1f;
  localparam logic [LOC_W-1:0] ASAP_LOC = 5'h10;

  typedef struct packed {
    logic              push;
    logic [QIDX_W-1:0] pushIdx;
    logic              pop;
    logic [QIDX_W-1:0] popIdx;
    logic              clear;
  } fcsStrobe_t;
endpackage

// File: rtl/fcs_store.sv
module fcs_store
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fcsStrobe_t               st,
  input  logic [ADDR_W+DATA_W-1:0] pushEntry,
  input  logic [QIDX_W-1:0]        selIdx,
  output logic [NUM_Q-1:0]         qEmpty,
  output logic [ADDR_W+DATA_W-1:0] headEntry
);
  localparam int EW    = ADDR_W + DATA_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [EW-1:0] heads [NUM_Q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < NUM_Q; g++) begin : gQueue
    logic [EW-1:0]    memQ [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] fill;
    logic             pushHit, popHit;

    assign pushHit = st.push && (st.pushIdx == QIDX_W'(g)) && (fill != CNT_W'(DEPTH));
    assign popHit  = st.pop && (st.popIdx == QIDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN || st.clear) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill  <= '0;
      end else begin
        if (pushHit) wrPtr <= bump(wrPtr);
        if (popHit)  rdPtr <= bump(rdPtr);
        fill <= fill + CNT_W'(pushHit) - CNT_W'(popHit);
      end
    end

    always_ff @(posedge clk) begin
      if (pushHit) memQ[wrPtr] <= pushEntry;
    end

    assign qEmpty[g] = (fill == '0);
    assign heads[g]  = memQ[rdPtr];

    // R11: a push into a full queue leaves the fill level unchanged
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
      (st.push && st.pushIdx == QIDX_W'(g) && fill == CNT_W'(DEPTH) && !popHit && !st.clear)
      |=> fill == CNT_W'(DEPTH));
  end

  assign headEntry = (selIdx < QIDX_W'(NUM_Q)) ? heads[selIdx] : '0;

  // R6: the control side never pops an empty queue
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |-> !qEmpty[st.popIdx]);

  // R7: a clear cycle leaves every queue empty
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> qEmpty == '1);
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int RST_CYC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [LOC_W-1:0]  wrLoc,
  input  logic [ADDR_W-1:0] wrAddrBits,
  input  logic              rstReq,
  input  logic [1:0]        runCmd,
  input  logic [1:0]        intCmd,
  input  logic              frameSync,
  input  logic              cmdReady,
  input  logic [NUM_Q-1:0]  qEmpty,
  output fcsStrobe_t        st,
  output logic [QIDX_W-1:0] selIdx,
  output logic [ADDR_W-1:0] addrLatch,
  output logic              cmdValid,
  output logic              irq
);
  localparam int RST_W = $clog2(RST_CYC);

  logic             phase;
  logic [LOC_W-1:0] locLatch;
  logic             runQ, rstBusy, armed, irqStat, irqEn;
  logic [RST_W-1:0] rstCnt;
  logic [3:0]       frameCnt;
  logic             ctrlWr, frameAdv, active, asapPend, curPend;
  logic [QIDX_W-1:0] tgtIdx;

  assign ctrlWr   = wrEn && (wrLoc == CTRL_LOC);
  assign frameAdv = frameSync && runQ;

  always_comb begin
    if (locLatch == ASAP_LOC)
      tgtIdx = QIDX_W'(ASAP_Q);
    else if (!locLatch[4])
      tgtIdx = (locLatch[3:0] == frameCnt - 4'd1) ? {1'b0, frameCnt} : {1'b0, locLatch[3:0]};
    else
      tgtIdx = {1'b0, frameCnt + locLatch[3:0]};
  end

  assign active   = runQ && !rstBusy;
  assign asapPend = !qEmpty[ASAP_Q];
  assign curPend  = !qEmpty[{1'b0, frameCnt}];
  assign cmdValid = active && (asapPend || curPend);
  assign selIdx   = asapPend ? QIDX_W'(ASAP_Q) : {1'b0, frameCnt};

  always_comb begin
    st.push    = wrEn && !ctrlWr && phase && !rstBusy;
    st.pushIdx = tgtIdx;
    st.pop     = cmdValid && cmdReady;
    st.popIdx  = selIdx;
    st.clear   = rstBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= 1'b0;
      locLatch  <= '0;
      addrLatch <= '0;
      runQ      <= 1'b0;
      rstBusy   <= 1'b0;
      rstCnt    <= '0;
      frameCnt  <= '0;
      armed     <= 1'b0;
      irqStat   <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (wrEn) begin
        if (ctrlWr) phase <= 1'b0;
        else if (!phase) begin
          phase     <= 1'b1;
          locLatch  <= wrLoc;
          addrLatch <= wrAddrBits;
        end else phase <= 1'b0;
      end

      if (ctrlWr && rstReq) begin
        rstBusy <= 1'b1;
        rstCnt  <= '0;
        runQ    <= 1'b0;
      end else begin
        if (rstBusy) begin
          rstCnt <= rstCnt + RST_W'(1);
          if (rstCnt == RST_W'(RST_CYC - 1)) rstBusy <= 1'b0;
        end
        if (ctrlWr && runCmd == 2'b11) runQ <= 1'b1;
        else if (ctrlWr && runCmd == 2'b10) runQ <= 1'b0;
      end

      if (frameAdv) frameCnt <= frameCnt + 4'd1;

      if (frameAdv) armed <= 1'b1;
      else if (armed && !curPend) begin
        irqStat <= 1'b1;
        armed   <= 1'b0;
      end

      if (ctrlWr) begin
        case (intCmd)
          2'd1: irqStat <= 1'b0;
          2'd2: irqEn   <= 1'b0;
          2'd3: irqEn   <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign irq = irqStat && irqEn;

  // R6: frame advances by one on a running frame pulse
  assert_frame_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && runQ) |=> frameCnt == $past(frameCnt) + 4'd1);

  // R6: frame holds otherwise
  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(frameSync && runQ) |=> $stable(frameCnt));

  // R7: queue reset stops the sequencer and opens the reset window
  assert_reset_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && rstReq) |=> (!runQ && rstBusy));

  // R2: control write puts the toggle in the address phase
  assert_toggle_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !phase);

  // R9: a status-clear command drops the interrupt on the next cycle
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && intCmd == 2'd1) |=> !irq);
endmodule

// File: rtl/frame_cmd_seq.sv
module frame_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DEPTH   = 4,
  parameter int RST_CYC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [4:0]        wrLoc,
  input  logic [31:0]       wrData,
  input  logic              frameSync,
  input  logic              cmdReady,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [31:0]       cmdData,
  output logic              irq
);
  fcsStrobe_t               st;
  logic [QIDX_W-1:0]        selIdx;
  logic [ADDR_W-1:0]        addrLatch;
  logic [NUM_Q-1:0]         qEmpty;
  logic [ADDR_W+DATA_W-1:0] headEntry;

  fcs_ctrl #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLoc(wrLoc),
    .wrAddrBits(wrData[ADDR_W-1:0]), .rstReq(wrData[14]),
    .runCmd(wrData[13:12]), .intCmd(wrData[1:0]),
    .frameSync(frameSync), .cmdReady(cmdReady), .qEmpty(qEmpty),
    .st(st), .selIdx(selIdx), .addrLatch(addrLatch),
    .cmdValid(cmdValid), .irq(irq)
  );

  fcs_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .st(st), .pushEntry({addrLatch, wrData}),
    .selIdx(selIdx), .qEmpty(qEmpty), .headEntry(headEntry)
  );

  assign cmdAddr = headEntry[ADDR_W+DATA_W-1:DATA_W];
  assign cmdData = headEntry[DATA_W-1:0];
endmodule

// File: tb/tb_frame_cmd_seq.sv
module tb_frame_cmd_seq;
  localparam int AW = 8;
  localparam int DP = 4;
  typedef logic [AW+31:0] ent_t;

  logic clk = 0, rstN = 0, wrEn = 0, frameSync = 0, cmdReady = 1;
  logic [4:0] wrLoc = '0;
  logic [31:0] wrData = '0;
  logic cmdValid, irq;
  logic [AW-1:0] cmdAddr;
  logic [31:0] cmdData;

  frame_cmd_seq #(.ADDR_W(AW), .DEPTH(DP), .RST_CYC(32)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLoc(wrLoc), .wrData(wrData),
    .frameSync(frameSync), .cmdReady(cmdReady), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  ent_t mq [17][$];
  int mcnt = 0, mbusyCnt = 0, mloc = 0, benchFrame = 0;
  bit mrun = 0, mbusy = 0, mphase = 0, marmed = 0, mstat = 0, men = 0;
  logic [AW-1:0] maddr = '0;

  int logData[$], logAddr[$], logFrame[$];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 17; i++) mq[i].delete();
      mcnt = 0; mbusyCnt = 0; mloc = 0; benchFrame = 0;
      mrun = 0; mbusy = 0; mphase = 0; marmed = 0; mstat = 0; men = 0; maddr = '0;
    end else begin
      bit run0, busy0, ph0, arm0, emptyCur, valid, pushing, fullPre, ctl;
      int cnt0, sel, idx;
      run0 = mrun; busy0 = mbusy; ph0 = mphase; arm0 = marmed; cnt0 = mcnt;
      emptyCur = (mq[cnt0].size() == 0);
      valid = run0 && !busy0 && (mq[16].size() > 0 || !emptyCur);
      sel = (mq[16].size() > 0) ? 16 : cnt0;
      ctl = wrEn && (wrLoc == 5'd31);
      pushing = wrEn && !ctl && ph0 && !busy0;
      if (mloc == 16) idx = 16;
      else if (mloc < 16) idx = (mloc == (cnt0 + 15) % 16) ? cnt0 : mloc;
      else idx = (cnt0 + mloc - 16) % 16;
      fullPre = (mq[idx].size() >= DP);
      if (busy0) begin
        for (int i = 0; i < 17; i++) mq[i].delete();
      end else begin
        if (valid && cmdReady) void'(mq[sel].pop_front());
        if (pushing && !fullPre) mq[idx].push_back({maddr, wrData});
      end
      if (wrEn) begin
        if (ctl) mphase = 0;
        else if (!ph0) begin mphase = 1; mloc = wrLoc; maddr = wrData[AW-1:0]; end
        else mphase = 0;
      end
      if (ctl && wrData[14]) begin mbusy = 1; mbusyCnt = 0; mrun = 0; end
      else begin
        if (busy0) begin if (mbusyCnt == 31) mbusy = 0; mbusyCnt++; end
        if (ctl && wrData[13:12] == 2'b11) mrun = 1;
        else if (ctl && wrData[13:12] == 2'b10) mrun = 0;
      end
      if (frameSync && run0) begin mcnt = (cnt0 + 1) % 16; benchFrame++; marmed = 1; end
      else if (arm0 && emptyCur) begin mstat = 1; marmed = 0; end
      if (ctl) begin
        if (wrData[1:0] == 2'd1) mstat = 0;
        else if (wrData[1:0] == 2'd2) men = 0;
        else if (wrData[1:0] == 2'd3) men = 1;
      end
    end
  end

  // compare every cycle, away from the clock edge
  always @(negedge clk) begin
    #5;
    if (rstN && !done) begin
      bit ev; int s; ent_t e;
      ev = mrun && !mbusy && (mq[16].size() > 0 || mq[mcnt].size() > 0);
      checks++;
      if (cmdValid !== ev) begin fails++; $display("FAIL R6 cmdValid act=%0b exp=%0b t=%0t", cmdValid, ev, $time); end
      if (ev) begin
        s = (mq[16].size() > 0) ? 16 : mcnt;
        e = mq[s][0];
        checks++;
        if ({cmdAddr, cmdData} !== e) begin
          fails++; $display("FAIL R1 cmd act=%h exp=%h t=%0t", {cmdAddr, cmdData}, e, $time);
        end
      end
      checks++;
      if (irq !== (mstat && men)) begin fails++; $display("FAIL R9 irq act=%0b exp=%0b", irq, mstat && men); end
      if (cmdValid && cmdReady) begin
        logData.push_back(int'(cmdData)); logAddr.push_back(int'(cmdAddr)); logFrame.push_back(benchFrame);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  function automatic int findFrame(input int d);
    for (int i = 0; i < logData.size(); i++) if (logData[i] == d) return logFrame[i];
    return -1;
  endfunction

  function automatic int findAddr(input int d);
    for (int i = 0; i < logData.size(); i++) if (logData[i] == d) return logAddr[i];
    return -1;
  endfunction

  task automatic hostWrite(input int loc, input int d);
    @(negedge clk); wrEn = 1; wrLoc = 5'(loc); wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic cmdWrite(input int loc, input int a, input int d);
    hostWrite(loc, a); hostWrite(loc, d);
  endtask

  task automatic pulseFrame();
    @(negedge clk); frameSync = 1;
    @(negedge clk); frameSync = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    waitCycles(4); rstN = 1; waitCycles(2);
    // R12 reset state
    check(cmdValid == 0, "R12 cmdValid", cmdValid, 0);
    check(irq == 0, "R12 irq", irq, 0);

    // R8 stopped: nothing issued
    cmdWrite(0, 'h11, 'h100);
    waitCycles(10);
    check(logData.size() == 0, "R8 stopped output", logData.size(), 0);
    hostWrite(31, 'h3000);
    waitCycles(5);
    check(findFrame('h100) == 0, "R8 run releases", findFrame('h100), 0);
    check(findAddr('h100) == 'h11, "R1 address", findAddr('h100), 'h11);

    // R4 immediate priority, R6 order under backpressure
    cmdReady = 0;
    cmdWrite(0, 'h21, 'h301); cmdWrite(0, 'h22, 'h302); cmdWrite(16, 'h23, 'h303);
    waitCycles(3);
    cmdReady = 1;
    waitCycles(6);
    n = logData.size();
    check(logData[n-3] == 'h303, "R4 immediate first", logData[n-3], 'h303);
    check(logData[n-2] == 'h301, "R6 order 1", logData[n-2], 'h301);
    check(logData[n-1] == 'h302, "R6 order 2", logData[n-1], 'h302);

    // R5 relative targets
    cmdWrite(19, 'h31, 'h400); cmdWrite(17, 'h32, 'h401);
    pulseFrame(); pulseFrame(); pulseFrame();
    check(findFrame('h401) == 1, "R5 plus one", findFrame('h401), 1);
    check(findFrame('h400) == 3, "R5 plus three", findFrame('h400), 3);

    // R3 absolute and just-missed, frame now 3
    cmdWrite(2, 'h41, 'h500); cmdWrite(5, 'h42, 'h501);
    waitCycles(3);
    pulseFrame(); pulseFrame();
    check(findFrame('h500) == 3, "R3 just missed", findFrame('h500), 3);
    check(findFrame('h501) == 5, "R3 absolute", findFrame('h501), 5);

    // R5 wrap: frame 5 plus 14 lands on frame 3 of the next lap
    cmdWrite(30, 'h51, 'h600);
    for (int i = 0; i < 14; i++) pulseFrame();
    check(findFrame('h600) == 19, "R5 wrap", findFrame('h600), 19);

    // R2 toggle reset by control write
    hostWrite(16, 'h77); hostWrite(31, 0); cmdWrite(16, 'h88, 'h700);
    waitCycles(3);
    check(findAddr('h700) == 'h88, "R2 toggle", findAddr('h700), 'h88);

    // R9 / R10 interrupt
    hostWrite(31, 1); hostWrite(31, 3); waitCycles(2);
    check(irq == 0, "R9 cleared", irq, 0);
    pulseFrame();
    check(irq == 1, "R10 frame done", irq, 1);
    hostWrite(31, 1); waitCycles(2);
    check(irq == 0, "R9 clear status", irq, 0);
    hostWrite(31, 2); pulseFrame();
    check(irq == 0, "R9 disabled", irq, 0);
    hostWrite(31, 3); waitCycles(2);
    check(irq == 1, "R9 enable shows status", irq, 1);
    hostWrite(31, 1);

    // R11 full queue, frame 21 -> target 23
    for (int i = 0; i < 5; i++) cmdWrite(18, 'h60 + i, 'h800 + i);
    pulseFrame(); pulseFrame(); waitCycles(6);
    for (int i = 0; i < 4; i++)
      check(findFrame('h800 + i) == 23, "R11 kept", findFrame('h800 + i), 23);
    check(findFrame('h804) == -1, "R11 dropped", findFrame('h804), -1);

    // R7 queue reset
    hostWrite(31, 'h2000);
    cmdWrite(16, 'h91, 'h900);
    hostWrite(31, 'h7000);
    cmdWrite(16, 'h92, 'h901);
    hostWrite(31, 'h3000);
    waitCycles(40);
    check(findFrame('h900) == -1, "R7 flushed", findFrame('h900), -1);
    check(findFrame('h901) == -1, "R7 write dropped", findFrame('h901), -1);
    cmdWrite(16, 'h93, 'h902); waitCycles(4);
    check(findFrame('h902) == 23, "R7 recovers", findFrame('h902), 23);

    waitCycles(4);
    summary();
  end
endmodule